// File: doc/BRIEF.md
# PCM Time-Slot Serial Port

This block moves companded voice bytes between a telephony codec core and a frame-synchronous serial bus. A bit clock and an 8 kHz frame-sync input arrive as ordinary inputs and are sampled by the system clock. The block finds each frame start from the frame-sync rising edge, counts bit positions, and drives one 8-bit byte onto a transmit pin with an output enable during a single chosen time slot. During the same slot it captures one byte from the receive pin.

Configuration inputs choose one of three frame-alignment modes, each with its own bit-clock edge polarity. They also choose one of two slot layouts, the first or second channel slot, and an enable. Further inputs select a 7-bit mode that leaves the last bit time undriven, register-byte substitution on either path, and a digital loopback. Bytes to and from the encoder and decoder pass on parallel ports. The whole configuration is taken only when a frame starts.

Top module: `pcm_tslot_port`

## Requirements
- R1: A frame starts only on a low-to-high change of `fsync` seen at a launch edge. How long `fsync` then stays high, from one bit period to half a frame, has no effect.
- R2: With `cfg_mode` = 2'b10 (aligned normal), bit position 0 is launched on the `bclk` rising edge at which `fsync` is first seen high. The transmit pin changes on `bclk` rising edges and the receive pin is sampled on `bclk` falling edges.
- R3: With `cfg_mode[1]` = 0 (early-sync mode, the reset default), `fsync` is first seen high at a `bclk` rising edge, and bit position 0 is launched one bit period later. The edges are the same as in R2.
- R4: With `cfg_mode` = 2'b11 (aligned inverted), the launch edge is the `bclk` falling edge and the sample edge is the rising edge. Frame start is detected at the falling edge.
- R5: The first channel slot (`cfg_sel_b2`=0) covers bit positions 0 to 7. The second slot covers positions 8 to 15 when `cfg_fmt2`=0, and positions 10 to 17 when `cfg_fmt2`=1, which leaves a two-bit gap.
- R6: The byte goes out most significant bit first. `tx_oe` is 0 at every bit position outside the selected slot.
- R7: With `cfg_en`=0, `tx_oe` stays 0, `dec_valid` never pulses and `rx_last` keeps its value.
- R8: With `cfg_seven`=1, `tx_oe` is 0 during the eighth bit of the slot, and the received least significant bit is stored as 0 whatever the pin carries.
- R9: After the eighth receive sample, `dec_valid` pulses for one cycle and `rx_last` holds the captured byte. `dec_byte` carries the captured byte, or `rx_sub_byte` when `cfg_sub_rx`=1. `rx_last` still holds the captured byte in that case.
- R10: With `cfg_sub_tx`=1, `tx_sub_byte` is sent in place of `enc_byte` in every frame.
- R11: With `cfg_loop`=1, the byte held in `rx_last` at frame start is sent, taking precedence over substitution.
- R12: After reset, `tx_oe` stays 0 for the whole first frame. Transmission begins in the second frame.
- R13: All `cfg_*` inputs are sampled at a frame start and hold for the whole frame. `enc_take` pulses once per frame, one cycle after the transmit byte is taken.
- R14: In reset, `tx_oe`, `tx_pin`, `dec_valid` and `rx_last` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than bclk |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock |
| fsync | input | 1 | Frame sync, rising edge marks the frame |
| cfg_mode | input | 2 | Frame alignment mode (0x early, 10 normal, 11 inverted) |
| cfg_fmt2 | input | 1 | Slot layout with two-bit gap before second slot |
| cfg_sel_b2 | input | 1 | Use second channel slot |
| cfg_en | input | 1 | Enable voice transfer |
| cfg_seven | input | 1 | 7-bit mode |
| cfg_loop | input | 1 | Digital loopback |
| cfg_sub_tx | input | 1 | Send tx_sub_byte instead of encoder byte |
| cfg_sub_rx | input | 1 | Feed rx_sub_byte to decoder |
| enc_byte | input | 8 | Encoder byte to transmit |
| tx_sub_byte | input | 8 | Substitute transmit byte |
| rx_sub_byte | input | 8 | Substitute decoder byte |
| rx_pin | input | 1 | Serial receive data |
| tx_pin | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit driver enable (0 = high impedance) |
| dec_byte | output | 8 | Byte for the decoder |
| dec_valid | output | 1 | One-cycle strobe, dec_byte new |
| rx_last | output | 8 | Most recently received byte |
| enc_take | output | 1 | One-cycle strobe after the transmit byte is taken |

## Verification
The bench builds the block with its defaults: 8 slot bits, a 2-bit gap, a 6-bit position counter and a two-frame power-up hold. A 32-period frame therefore holds every slot placement, including the gapped second slot that ends at position 17. The two-frame hold is short enough that the bench can watch the first silent frame and the first transmitting frame right after reset. The bench drives `bclk` with four system cycles per half period. It puts wrong data on the receive pin during each launch half, so sampling on the wrong edge shows up, and it samples the transmit pin at the start of the sample half.

// File: rtl/pcm_tslot_pkg.sv
package pcm_tslot_pkg;

    typedef enum logic [1:0] {
        TM_EARLY    = 2'b00,
        TM_EARLY_X  = 2'b01,
        TM_NORMAL   = 2'b10,
        TM_INVERTED = 2'b11
    } tmode_e;

    typedef struct packed {
        logic fmt2;
        logic sel_b2;
        logic en;
        logic seven;
        logic loop;
        logic sub_tx;
        logic sub_rx;
    } slot_cfg_t;

    function automatic logic mode_is_early(input tmode_e m);
        return (m == TM_EARLY) || (m == TM_EARLY_X);
    endfunction

    function automatic int slot_base(input logic fmt2, input logic sel_b2,
                                     input int nbits, input int gap);
        if (!sel_b2) return 0;
        return fmt2 ? (nbits + gap) : nbits;
    endfunction

endpackage

// File: rtl/pcm_edge_detect.sv
module pcm_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic bclk,
    input  logic inverted,
    output logic launch_ev,
    output logic cap_ev
);
    logic bclk_q;
    logic rise, fall;

    always_ff @(posedge clk) begin
        if (rst) bclk_q <= 1'b0;
        else     bclk_q <= bclk;
    end

    always_comb begin
        rise      = bclk & ~bclk_q;
        fall      = ~bclk & bclk_q;
        launch_ev = inverted ? fall : rise;
        cap_ev    = inverted ? rise : fall;
    end
endmodule

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
    parameter int POS_W          = 6,
    parameter int POWERUP_FRAMES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch_ev,
    input  logic             fsync,
    input  logic             early,
    output logic             frame_begin,
    output logic [POS_W-1:0] pos_n,
    output logic             pos_valid_n,
    output logic             armed_n,
    output logic [POS_W-1:0] pos,
    output logic             pos_valid
);
    localparam int ARM_W = $clog2(POWERUP_FRAMES + 1);
    localparam logic [ARM_W-1:0] ARM_FULL = ARM_W'(POWERUP_FRAMES);
    localparam logic [POS_W-1:0] POS_MAX  = '1;

    logic             fs_prev;
    logic             pend;
    logic             det;
    logic [ARM_W-1:0] arm_cnt, arm_cnt_n;

    always_comb begin
        det         = fsync & ~fs_prev;
        frame_begin = launch_ev & (early ? pend : det);
        pos_valid_n = pos_valid | frame_begin;
        if (frame_begin)                        pos_n = '0;
        else if (pos_valid && pos != POS_MAX)   pos_n = pos + 1'b1;
        else                                    pos_n = pos;
        if (frame_begin && arm_cnt != ARM_FULL) arm_cnt_n = arm_cnt + 1'b1;
        else                                    arm_cnt_n = arm_cnt;
        armed_n = (arm_cnt_n == ARM_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_prev   <= 1'b0;
            pend      <= 1'b0;
            pos       <= '0;
            pos_valid <= 1'b0;
            arm_cnt   <= '0;
        end else if (launch_ev) begin
            fs_prev   <= fsync;
            pend      <= early & det;
            pos       <= pos_n;
            pos_valid <= pos_valid_n;
            arm_cnt   <= arm_cnt_n;
        end
    end
endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter
    import pcm_tslot_pkg::*;
#(
    parameter int SLOT_BITS = 8,
    parameter int GAP_BITS  = 2,
    parameter int POS_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch_ev,
    input  logic                 cap_ev,
    input  logic                 frame_begin,
    input  slot_cfg_t            cfg_n,
    input  slot_cfg_t            cfg_q,
    input  logic [POS_W-1:0]     pos_n,
    input  logic                 pos_valid_n,
    input  logic                 armed_n,
    input  logic [POS_W-1:0]     pos,
    input  logic                 pos_valid,
    input  logic [SLOT_BITS-1:0] enc_byte,
    input  logic [SLOT_BITS-1:0] tx_sub_byte,
    input  logic [SLOT_BITS-1:0] rx_sub_byte,
    input  logic                 rx_pin,
    output logic                 tx_pin,
    output logic                 tx_oe,
    output logic [SLOT_BITS-1:0] dec_byte,
    output logic                 dec_valid,
    output logic [SLOT_BITS-1:0] rx_last
);
    localparam int IDX_W = $clog2(SLOT_BITS);

    logic [SLOT_BITS-1:0] tx_byte_q, tx_byte_n, load_byte;
    logic [SLOT_BITS-1:0] rx_sh, rx_word;
    int                   tx_off, rx_off;
    logic                 tx_hit, tx_lsb, tx_bit;
    logic                 rx_hit, rx_lsb, rx_bit;
    logic [IDX_W-1:0]     tx_idx;

    always_comb begin
        if (cfg_n.loop)        load_byte = rx_last;
        else if (cfg_n.sub_tx) load_byte = tx_sub_byte;
        else                   load_byte = enc_byte;
        tx_byte_n = frame_begin ? load_byte : tx_byte_q;

        tx_off = int'(pos_n) - slot_base(cfg_n.fmt2, cfg_n.sel_b2, SLOT_BITS, GAP_BITS);
        tx_hit = pos_valid_n && (tx_off >= 0) && (tx_off < SLOT_BITS);
        tx_lsb = (tx_off == SLOT_BITS - 1);
        tx_idx = tx_hit ? IDX_W'(SLOT_BITS - 1 - tx_off) : '0;
        tx_bit = tx_hit ? tx_byte_n[tx_idx] : 1'b0;

        rx_off  = int'(pos) - slot_base(cfg_q.fmt2, cfg_q.sel_b2, SLOT_BITS, GAP_BITS);
        rx_hit  = pos_valid && cfg_q.en && (rx_off >= 0) && (rx_off < SLOT_BITS);
        rx_lsb  = (rx_off == SLOT_BITS - 1);
        rx_bit  = (cfg_q.seven && rx_lsb) ? 1'b0 : rx_pin;
        rx_word = {rx_sh[SLOT_BITS-2:0], rx_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_byte_q <= '0;
            tx_pin    <= 1'b0;
            tx_oe     <= 1'b0;
        end else if (launch_ev) begin
            tx_byte_q <= tx_byte_n;
            tx_pin    <= tx_bit;
            tx_oe     <= armed_n && cfg_n.en && tx_hit && !(cfg_n.seven && tx_lsb);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh     <= '0;
            rx_last   <= '0;
            dec_byte  <= '0;
            dec_valid <= 1'b0;
        end else begin
            dec_valid <= 1'b0;
            if (cap_ev && rx_hit) begin
                rx_sh <= rx_word;
                if (rx_lsb) begin
                    rx_last   <= rx_word;
                    dec_byte  <= cfg_q.sub_rx ? rx_sub_byte : rx_word;
                    dec_valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_tslot_port.sv
module pcm_tslot_port
    import pcm_tslot_pkg::*;
#(
    parameter int SLOT_BITS      = 8,
    parameter int GAP_BITS       = 2,
    parameter int POS_W          = 6,
    parameter int POWERUP_FRAMES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bclk,
    input  logic                 fsync,
    input  logic [1:0]           cfg_mode,
    input  logic                 cfg_fmt2,
    input  logic                 cfg_sel_b2,
    input  logic                 cfg_en,
    input  logic                 cfg_seven,
    input  logic                 cfg_loop,
    input  logic                 cfg_sub_tx,
    input  logic                 cfg_sub_rx,
    input  logic [SLOT_BITS-1:0] enc_byte,
    input  logic [SLOT_BITS-1:0] tx_sub_byte,
    input  logic [SLOT_BITS-1:0] rx_sub_byte,
    input  logic                 rx_pin,
    output logic                 tx_pin,
    output logic                 tx_oe,
    output logic [SLOT_BITS-1:0] dec_byte,
    output logic                 dec_valid,
    output logic [SLOT_BITS-1:0] rx_last,
    output logic                 enc_take
);
    tmode_e           mode_q;
    slot_cfg_t        cfg_q, cfg_in, cfg_n;
    logic             launch_ev, cap_ev, frame_begin;
    logic [POS_W-1:0] pos_n, pos;
    logic             pos_valid_n, pos_valid, armed_n;

    always_comb begin
        cfg_in = '{fmt2: cfg_fmt2, sel_b2: cfg_sel_b2, en: cfg_en, seven: cfg_seven,
                   loop: cfg_loop, sub_tx: cfg_sub_tx, sub_rx: cfg_sub_rx};
        cfg_n  = frame_begin ? cfg_in : cfg_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= TM_EARLY;
            cfg_q    <= '0;
            enc_take <= 1'b0;
        end else begin
            enc_take <= frame_begin;
            if (frame_begin) begin
                mode_q <= tmode_e'(cfg_mode);
                cfg_q  <= cfg_in;
            end
        end
    end

    pcm_edge_detect u_edge (
        .clk       (clk),
        .rst       (rst),
        .bclk      (bclk),
        .inverted  (mode_q == TM_INVERTED),
        .launch_ev (launch_ev),
        .cap_ev    (cap_ev)
    );

    pcm_frame_timer #(.POS_W(POS_W), .POWERUP_FRAMES(POWERUP_FRAMES)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .launch_ev   (launch_ev),
        .fsync       (fsync),
        .early       (mode_is_early(mode_q)),
        .frame_begin (frame_begin),
        .pos_n       (pos_n),
        .pos_valid_n (pos_valid_n),
        .armed_n     (armed_n),
        .pos         (pos),
        .pos_valid   (pos_valid)
    );

    pcm_slot_shifter #(.SLOT_BITS(SLOT_BITS), .GAP_BITS(GAP_BITS), .POS_W(POS_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .launch_ev   (launch_ev),
        .cap_ev      (cap_ev),
        .frame_begin (frame_begin),
        .cfg_n       (cfg_n),
        .cfg_q       (cfg_q),
        .pos_n       (pos_n),
        .pos_valid_n (pos_valid_n),
        .armed_n     (armed_n),
        .pos         (pos),
        .pos_valid   (pos_valid),
        .enc_byte    (enc_byte),
        .tx_sub_byte (tx_sub_byte),
        .rx_sub_byte (rx_sub_byte),
        .rx_pin      (rx_pin),
        .tx_pin      (tx_pin),
        .tx_oe       (tx_oe),
        .dec_byte    (dec_byte),
        .dec_valid   (dec_valid),
        .rx_last     (rx_last)
    );
endmodule

// File: rtl/pcm_tslot_port_chk.sv
module pcm_tslot_port_chk #(
    parameter int POWERUP_FRAMES = 2
) (
    input logic clk,
    input logic rst,
    input logic launch_ev,
    input logic cap_ev,
    input logic frame_begin,
    input logic tx_oe,
    input logic tx_pin,
    input logic dec_valid
);
    int seen_frames;

    always_ff @(posedge clk) begin
        if (rst)                                                seen_frames <= 0;
        else if (frame_begin && seen_frames < POWERUP_FRAMES)   seen_frames <= seen_frames + 1;
    end

    // R1: a frame can only begin on a launch edge
    a_r1_begin_on_launch: assert property (@(posedge clk) disable iff (rst)
        frame_begin |-> launch_ev);

    // R2: launch and sample edges never coincide
    a_r2_edges_disjoint: assert property (@(posedge clk) disable iff (rst)
        !(launch_ev && cap_ev));

    // R6: the transmit pin and its enable move only on launch edges
    a_r6_tx_moves_on_launch: assert property (@(posedge clk) disable iff (rst)
        !launch_ev |=> ($stable(tx_oe) && $stable(tx_pin)));

    // R9: decoder strobe lasts one cycle
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (rst)
        dec_valid |=> !dec_valid);

    // R9: decoder strobe follows a sample edge
    a_r9_strobe_after_sample: assert property (@(posedge clk) disable iff (rst)
        dec_valid |-> $past(cap_ev));

    // R12: no driving before the power-up frame count is reached
    a_r12_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        tx_oe |-> (seen_frames >= POWERUP_FRAMES));
endmodule

bind pcm_tslot_port pcm_tslot_port_chk #(.POWERUP_FRAMES(POWERUP_FRAMES)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .launch_ev   (launch_ev),
    .cap_ev      (cap_ev),
    .frame_begin (frame_begin),
    .tx_oe       (tx_oe),
    .tx_pin      (tx_pin),
    .dec_valid   (dec_valid)
);

// File: tb/pcm_tslot_port_test.sv
`timescale 1ns/1ps
module pcm_tslot_port_test;
    localparam int NB = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bclk = 1'b0, fsync = 1'b0, rx_pin = 1'b1;
    logic [1:0] c_mode = 2'b00;
    logic       c_fmt2 = 0, c_sel = 0, c_en = 0, c_seven = 0, c_loop = 0, c_subtx = 0, c_subrx = 0;
    logic [7:0] enc_byte = 8'h00, tx_sub = 8'h00, rx_sub = 8'h00;
    logic       tx_pin, tx_oe, dec_valid, enc_take;
    logic [7:0] dec_byte, rx_last;

    int         checks = 0, errors = 0;
    int         n_val = 0, n_take = 0;
    logic [7:0] v_byte = 8'h00;
    logic [7:0] rx_byte = 8'h00;
    int         fs_len = 1;
    bit         mid_off = 0;

    pcm_tslot_port uut (
        .clk(clk), .rst(rst), .bclk(bclk), .fsync(fsync), .cfg_mode(c_mode),
        .cfg_fmt2(c_fmt2), .cfg_sel_b2(c_sel), .cfg_en(c_en), .cfg_seven(c_seven),
        .cfg_loop(c_loop), .cfg_sub_tx(c_subtx), .cfg_sub_rx(c_subrx),
        .enc_byte(enc_byte), .tx_sub_byte(tx_sub), .rx_sub_byte(rx_sub), .rx_pin(rx_pin),
        .tx_pin(tx_pin), .tx_oe(tx_oe), .dec_byte(dec_byte), .dec_valid(dec_valid),
        .rx_last(rx_last), .enc_take(enc_take)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        if (dec_valid) begin n_val++; v_byte = dec_byte; end
        if (enc_take) n_take++;
    end

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic run_frame(input bit chk, input bit armed, input string req);
        int d, base, q, off;
        bit en0, rev, inrx, oe_e;
        logic [7:0] rxm, txb;
        rev  = (c_mode == 2'b11);
        d    = (c_mode[1] == 1'b0) ? 1 : 0;
        base = c_sel ? (c_fmt2 ? 10 : 8) : 0;
        en0  = c_en;
        rxm  = c_seven ? {rx_byte[7:1], 1'b0} : rx_byte;
        txb  = c_loop ? rxm : (c_subtx ? tx_sub : enc_byte);
        n_val = 0; n_take = 0;
        for (int p = 0; p < NB; p++) begin
            q    = p - d;
            off  = q - base;
            inrx = (off >= 0) && (off < 8);
            bclk  = rev ? 1'b0 : 1'b1;
            fsync = (p < fs_len);
            rx_pin = inrx ? ~rx_byte[7-off] : 1'b1;
            if (mid_off && p == 3) c_en = 1'b0;
            repeat (4) @(negedge clk);
            if (chk) begin
                oe_e = armed && en0 && inrx && !(c_seven && off == 7);
                check(tx_oe == oe_e, req, $sformatf("tx_oe pos %0d", q), tx_oe, oe_e);
                if (oe_e) check(tx_pin == txb[7-off], req, $sformatf("tx_pin pos %0d", q), tx_pin, txb[7-off]);
            end
            bclk   = ~bclk;
            rx_pin = inrx ? rx_byte[7-off] : 1'b1;
            repeat (4) @(negedge clk);
        end
        if (chk) begin
            check(n_take == 1, "R13", "enc_take pulses", n_take, 1);
            check(n_val == (en0 ? 1 : 0), req, "dec_valid pulses", n_val, en0 ? 1 : 0);
            if (en0) begin
                check(v_byte == (c_subrx ? rx_sub : rxm), req, "dec_byte", v_byte, c_subrx ? rx_sub : rxm);
                check(rx_last == rxm, req, "rx_last", rx_last, rxm);
            end
        end
    endtask

    task automatic pair(input string req);
        run_frame(0, 1, req);
        run_frame(1, 1, req);
    endtask

    initial begin
        #(20ns * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        repeat (5) @(negedge clk);
        // R14: reset state
        check(tx_oe == 0 && tx_pin == 0, "R14", "tx idle", {tx_oe, tx_pin}, 0);
        check(dec_valid == 0, "R14", "dec_valid", dec_valid, 0);
        check(rx_last == 0, "R14", "rx_last", rx_last, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R12 + R3: early-sync mode, first frame silent, second transmits
        c_mode = 2'b00; c_en = 1; enc_byte = 8'hA5; rx_byte = 8'h3C; fs_len = 1;
        run_frame(1, 0, "R12");
        run_frame(1, 1, "R3");

        // R2 + R5 + R1: aligned normal, second slot, long sync pulse
        c_mode = 2'b10; c_sel = 1; c_fmt2 = 0; enc_byte = 8'h96; rx_byte = 8'hC3; fs_len = 16;
        pair("R2");
        // R5: first slot, single-period sync
        c_sel = 0; fs_len = 1; enc_byte = 8'h1E; rx_byte = 8'h81;
        pair("R5");
        // R8: 7-bit mode
        c_seven = 1; rx_byte = 8'hFF; enc_byte = 8'hFF;
        pair("R8");
        c_seven = 0;
        // R10: transmit substitution
        c_subtx = 1; tx_sub = 8'h5A; rx_byte = 8'h66;
        pair("R10");
        // R11: loopback wins over substitution
        c_loop = 1; rx_byte = 8'hB4;
        pair("R11");
        c_loop = 0; c_subtx = 0;
        // R9: receive substitution
        c_subrx = 1; rx_sub = 8'h81; rx_byte = 8'h4D;
        pair("R9");
        c_subrx = 0;
        // R7: disabled, rx_last unchanged
        c_en = 0; rx_byte = 8'h27;
        run_frame(0, 1, "R7");
        held = rx_last;
        run_frame(1, 1, "R7");
        check(rx_last == held, "R7", "rx_last kept", rx_last, held);
        // R13: enable dropped mid-frame takes effect only at next frame
        c_en = 1; rx_byte = 8'hE1; enc_byte = 8'h3F;
        run_frame(0, 1, "R13");
        mid_off = 1;
        c_en = 1;
        run_frame(1, 1, "R13");
        mid_off = 0;
        // R4: inverted mode, gapped second slot
        c_en = 1; c_mode = 2'b11; c_sel = 1; c_fmt2 = 1; enc_byte = 8'hC6; rx_byte = 8'h39; fs_len = 1;
        pair("R4");
        // R3 + R5: early-sync mode, gapped second slot, 5-period sync
        c_mode = 2'b00; fs_len = 5; enc_byte = 8'h72; rx_byte = 8'hD8;
        pair("R3");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule